// File: doc/BRIEF.md
# Full-Duplex Two-Wire Word Link

This block moves one data word in each direction between two identical engines that share a clock of the same frequency. Each engine drives one output wire and reads one input wire, and no clock travels with the data. One engine has the master role and the other has the slave role. A level handshake on the two data wires aligns them. After that, both engines shift out their own word and shift in the partner's word at the same time. Each engine keeps time with its own counter, which runs for the same number of clocks per bit at both ends.

To start a transfer, the user loads a parallel transmit word and pulses start. When the exchange finishes, the engine pulses done and presents the received word on a parallel output. If the partner never answers the handshake, the engine gives up after a bounded wait, pulses an error flag and returns its wire to the idle-high level.

Each input wire passes through a two-flop synchronizer. The engine then samples it at a fixed offset inside each bit period. This offset is half the period plus the synchronizer delay, which places the sample well away from the partner's edge. The offset leaves margin for slow edges and for the small skew between the two ends that the handshake leaves behind.

Top module: `wl_word_link`

## Requirements
- R1: During and after reset, line_out is 1, done is 0, timeout_err is 0 and rx_word is all zeros.
- R2: When the master role gets start while idle, it drives line_out to 0 on the next cycle. When the slave role gets start, it keeps line_out at 1 until its synchronized line_in has gone low. Only then does it drive its line to 0.
- R3: After one handshake, the master's rx_word equals the tx_word that the slave captured, and the slave's rx_word equals the tx_word that the master captured.
- R4: On the wire, bit k of the transfer (k = 0 first) carries tx_word[WORD_BITS-1-k], so the most significant bit goes first. Each bit holds line_out steady for exactly BIT_CLKS clocks.
- R5: Each received bit enters rx at the least significant end, so the first bit received ends up in rx_word[WORD_BITS-1].
- R6: The engine samples line_in through a SYNC_STAGES-flop synchronizer, at phase SAMPLE_OFS = BIT_CLKS/2 + SYNC_STAGES of each bit period. This gives error-free exchange with the skew that the handshake leaves between the two ends.
- R7: After WORD_BITS bit periods, done is 1 for exactly one clock. In that same cycle the new rx_word appears, and rx_word then stays unchanged until the next done.
- R8: In the cycle in which done is 1, line_out is already back at 1.
- R9: If the partner does not complete the handshake within TIMEOUT_CLKS clocks of start, timeout_err is 1 for one clock. In that cycle line_out is 1, and no done follows.
- R10: The engine captures tx_word at the start pulse. A start pulse while a handshake or transfer is in progress has no effect, and neither does a change of tx_word at that time.
- R11: BIT_CLKS is a parameter. A 20-clock bit period exchanges words as correctly as the default 12-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared frequency with the partner |
| rst_n | input | 1 | Synchronous active-low reset |
| role_master | input | 1 | 1 selects the master role, 0 selects the slave role; sampled at start |
| start | input | 1 | One-clock pulse that begins a handshake when the engine is idle |
| tx_word | input | WORD_BITS | Word to send, captured at start |
| rx_word | output | WORD_BITS | Last word received, updated with done |
| done | output | 1 | One-clock pulse at the end of an exchange |
| timeout_err | output | 1 | One-clock pulse when the handshake times out |
| line_out | output | 1 | Serial data wire to the partner, idle high |
| line_in | input | 1 | Serial data wire from the partner |

## Verification
The checker assumes that line_in comes from a partner engine with the same parameters, connected back to back. It also assumes that start is a single-clock pulse, and that role_master stays steady around it. The bench wires two engines crosswise for each bit period it tries. It pulses start only on falling clock edges. It keeps the random gap between the two start pulses far below the timeout, except in the directed cases that start one side alone to provoke the timeout.

// File: rtl/wl_pkg.sv
// Shared types for the two-wire word link.
// Assumes: nothing beyond the enum encoding being private to the link.
package wl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // line high, waiting for start
        ST_ARM,    // master only: line low, wait to see the partner high
        ST_WAIT,   // wait to see the partner low
        ST_HOLD,   // slave only: line low, let the master catch the edge
        ST_XFER    // shifting bits in both directions
    } wl_state_e;

endpackage

// File: rtl/wl_sync.sv
// Multi-flop synchronizer for an asynchronous wire.
// Assumes STAGES >= 2. The reset value matches the idle level of the wire.
module wl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the wire value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/wl_bit_timer.sv
// Bit-period timing for one transfer. It keeps a phase counter inside the
// bit period and a bit counter that counts down from WORD_BITS. It flags
// the sample phase, the end of each period and the end of the last period.
// Assumes SAMPLE_OFS < BIT_CLKS. load and active are never both high.
module wl_bit_timer #(
    parameter int BIT_CLKS   = 12,
    parameter int WORD_BITS  = 32,
    parameter int SAMPLE_OFS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic active,
    output logic sample_now,
    output logic period_end,
    output logic last_end,
    output logic phase_zero
);

    localparam int PW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BW = $clog2(WORD_BITS + 1);

    logic [PW-1:0] phase;
    logic [BW-1:0] bits_left;

    // Phase wraps every BIT_CLKS clocks; the bit count drops at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            bits_left <= '0;
        end else if (load) begin
            phase     <= '0;
            bits_left <= BW'(WORD_BITS);
        end else if (active) begin
            if (phase == PW'(BIT_CLKS - 1)) begin
                phase     <= '0;
                bits_left <= bits_left - 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign sample_now = active && (phase == PW'(SAMPLE_OFS));
    assign period_end = active && (phase == PW'(BIT_CLKS - 1));
    assign last_end   = period_end && (bits_left == BW'(1));
    assign phase_zero = (phase == '0);

endmodule

// File: rtl/wl_shifter.sv
// Transmit and receive shift registers. Transmit leaves from the MSB end;
// receive enters at the LSB end. rx_next is the receive value after this
// cycle's sample, so the last bit can be taken in the same cycle it arrives.
// Assumes capture happens only while the link is idle.
module wl_shifter #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [WORD_BITS-1:0] tx_word,
    input  logic                 advance,
    input  logic                 sample,
    input  logic                 rx_bit,
    output logic                 tx_bit,
    output logic [WORD_BITS-1:0] rx_next
);

    logic [WORD_BITS-1:0] tx_sr;
    logic [WORD_BITS-1:0] rx_sr;

    // Load the outgoing word at start; drop the sent MSB on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_sr <= '0;
        else if (capture) tx_sr <= tx_word;
        else if (advance) tx_sr <= {tx_sr[WORD_BITS-2:0], 1'b0};
    end

    // Next receive value, with the sampled bit appended at the LSB.
    always_comb begin
        rx_next = rx_sr;
        if (sample) rx_next = {rx_sr[WORD_BITS-2:0], rx_bit};
    end

    // Hold the partial received word; clear it at start.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_sr <= '0;
        else if (capture) rx_sr <= '0;
        else              rx_sr <= rx_next;
    end

    assign tx_bit = tx_sr[WORD_BITS-1];

endmodule

// File: rtl/wl_word_link.sv
// Full-duplex word exchange over one wire per direction, with no clock wire.
// A level handshake aligns the two ends. Each end then clocks WORD_BITS
// bits out and in at BIT_CLKS clocks per bit. It samples mid-bit through a
// synchronizer. A bounded wait aborts a handshake that gets no answer.
// Assumes the partner is the same block with the same parameters, clocked
// at the same frequency, and that start is a single-clock pulse.
module wl_word_link
    import wl_pkg::*;
#(
    parameter int WORD_BITS    = 32,
    parameter int BIT_CLKS     = 12,
    parameter int SYNC_STAGES  = 2,
    parameter int SAMPLE_OFS   = BIT_CLKS / 2 + SYNC_STAGES,
    parameter int HOLD_CLKS    = SYNC_STAGES + 2,
    parameter int TIMEOUT_CLKS = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 role_master,
    input  logic                 start,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 done,
    output logic                 timeout_err,
    output logic                 line_out,
    input  logic                 line_in
);

    localparam int CW = $clog2(TIMEOUT_CLKS + 1);

    wl_state_e            state;
    logic                 is_master_q;
    logic [CW-1:0]        wait_cnt;
    logic                 peer_hi;
    logic                 tx_bit;
    logic [WORD_BITS-1:0] rx_next;
    logic                 sample_now, period_end, last_end, phase_zero;
    logic                 in_xfer, idle, go_xfer, advance, capture, tmo_hit;

    wl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (peer_hi)
    );

    wl_bit_timer #(
        .BIT_CLKS   (BIT_CLKS),
        .WORD_BITS  (WORD_BITS),
        .SAMPLE_OFS (SAMPLE_OFS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (go_xfer),
        .active     (in_xfer),
        .sample_now (sample_now),
        .period_end (period_end),
        .last_end   (last_end),
        .phase_zero (phase_zero)
    );

    wl_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .tx_word (tx_word),
        .advance (advance),
        .sample  (sample_now),
        .rx_bit  (peer_hi),
        .tx_bit  (tx_bit),
        .rx_next (rx_next)
    );

    // Decode the state and the handshake events that step it.
    always_comb begin
        in_xfer = (state == ST_XFER);
        idle    = (state == ST_IDLE);
        capture = idle && start;
        go_xfer = ((state == ST_WAIT) && !peer_hi && is_master_q) ||
                  ((state == ST_HOLD) && (wait_cnt == CW'(HOLD_CLKS - 1)));
        advance = go_xfer || (period_end && !last_end);
        tmo_hit = (wait_cnt == CW'(TIMEOUT_CLKS - 1));
    end

    // Handshake, transfer and abort sequencing with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            is_master_q <= 1'b0;
            wait_cnt    <= '0;
            line_out    <= 1'b1;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rx_word     <= '0;
        end else begin
            done        <= 1'b0;
            timeout_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        is_master_q <= role_master;
                        wait_cnt    <= '0;
                        if (role_master) begin
                            line_out <= 1'b0;
                            state    <= ST_ARM;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ARM: begin
                    if (peer_hi) begin
                        state    <= ST_WAIT;
                        wait_cnt <= wait_cnt + 1'b1;
                    end else if (tmo_hit) begin
                        state       <= ST_IDLE;
                        line_out    <= 1'b1;
                        timeout_err <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!peer_hi) begin
                        if (is_master_q) begin
                            state    <= ST_XFER;
                            line_out <= tx_bit;
                        end else begin
                            state    <= ST_HOLD;
                            line_out <= 1'b0;
                            wait_cnt <= '0;
                        end
                    end else if (tmo_hit) begin
                        state       <= ST_IDLE;
                        line_out    <= 1'b1;
                        timeout_err <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (go_xfer) begin
                        state    <= ST_XFER;
                        line_out <= tx_bit;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (last_end) begin
                        state    <= ST_IDLE;
                        line_out <= 1'b1;
                        done     <= 1'b1;
                        rx_word  <= rx_next;
                    end else if (period_end) begin
                        line_out <= tx_bit;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wl_link_checker.sv
// Protocol checker for wl_word_link, attached to every instance by bind.
// Assumes a single-clock start pulse and a partner engine on line_in.
module wl_link_checker #(
    parameter int WORD_BITS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 role_master,
    input logic                 start,
    input logic                 idle,
    input logic                 in_xfer,
    input logic                 phase_zero,
    input logic                 done,
    input logic                 timeout_err,
    input logic                 line_out,
    input logic [WORD_BITS-1:0] rx_word
);

    assert_master_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(idle) && $past(role_master)) |-> !line_out);

    assert_bit_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && $past(in_xfer) && !phase_zero) |-> $stable(line_out));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_word));

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> line_out);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    assert_err_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (line_out && !done));

endmodule

bind wl_word_link wl_link_checker #(.WORD_BITS(WORD_BITS)) u_link_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_master (role_master),
    .start       (start),
    .idle        (idle),
    .in_xfer     (in_xfer),
    .phase_zero  (phase_zero),
    .done        (done),
    .timeout_err (timeout_err),
    .line_out    (line_out),
    .rx_word     (rx_word)
);

// File: tb/wl_word_link_test.sv
module wl_word_link_test;

    localparam int W   = 32;
    localparam int PA  = 12;
    localparam int PB  = 20;
    localparam int TMO = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    // Pair A: 12-clock bit; pair B: 20-clock bit.
    logic         a_sm = 0, a_ss = 0, b_sm = 0, b_ss = 0;
    logic [W-1:0] a_txm = '0, a_txs = '0, b_txm = '0, b_txs = '0;
    logic [W-1:0] a_rxm, a_rxs, b_rxm, b_rxs;
    logic         a_dm, a_ds, a_em, a_es, a_m2s, a_s2m;
    logic         b_dm, b_ds, b_em, b_es, b_m2s, b_s2m;

    wl_word_link #(.WORD_BITS(W), .BIT_CLKS(PA), .TIMEOUT_CLKS(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .role_master(1'b1), .start(a_sm), .tx_word(a_txm),
        .rx_word(a_rxm), .done(a_dm), .timeout_err(a_em), .line_out(a_m2s), .line_in(a_s2m));
    wl_word_link #(.WORD_BITS(W), .BIT_CLKS(PA), .TIMEOUT_CLKS(TMO)) peer (
        .clk(clk), .rst_n(rst_n), .role_master(1'b0), .start(a_ss), .tx_word(a_txs),
        .rx_word(a_rxs), .done(a_ds), .timeout_err(a_es), .line_out(a_s2m), .line_in(a_m2s));
    wl_word_link #(.WORD_BITS(W), .BIT_CLKS(PB), .TIMEOUT_CLKS(TMO)) uut_b (
        .clk(clk), .rst_n(rst_n), .role_master(1'b1), .start(b_sm), .tx_word(b_txm),
        .rx_word(b_rxm), .done(b_dm), .timeout_err(b_em), .line_out(b_m2s), .line_in(b_s2m));
    wl_word_link #(.WORD_BITS(W), .BIT_CLKS(PB), .TIMEOUT_CLKS(TMO)) peer_b (
        .clk(clk), .rst_n(rst_n), .role_master(1'b0), .start(b_ss), .tx_word(b_txs),
        .rx_word(b_rxs), .done(b_ds), .timeout_err(b_es), .line_out(b_s2m), .line_in(b_m2s));

    // Bench-side record of each pair's traffic.
    logic [1023:0] hist_a = '1, hist_b = '1;
    logic [W-1:0]  exp_a = '0, exp_b = '0;
    logic [W-1:0]  cap_m, cap_s;
    int            n_mdone = 0, n_sdone = 0, n_merr = 0, n_serr = 0;
    bit            sel_b = 0;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // The bit that the wire should carry in position k (MSB first).
    function automatic logic exp_wire_bit(input logic [W-1:0] word, input int k);
        return word[W-1-k];
    endfunction

    // Rebuild the word from the wire history, one sample mid-bit per period.
    function automatic logic [W-1:0] wire_word(input logic [1023:0] h, input int p);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[W-1-k] = h[W*p - k*p - p/2];
        return r;
    endfunction

    // Monitor: record wire history and count done/error pulses of the active pair.
    always @(negedge clk) begin
        logic [W-1:0] rebuilt;
        hist_a = {hist_a[1022:0], a_m2s};
        hist_b = {hist_b[1022:0], b_m2s};
        if (!sel_b && a_dm) begin
            n_mdone++; cap_m = a_rxm;
            rebuilt = wire_word(hist_a, PA);
            check(rebuilt == exp_a && exp_wire_bit(exp_a, 0) == rebuilt[W-1],
                  "R4 wire order and period", rebuilt, exp_a);
            check(a_m2s == 1'b1, "R8 line high at done", W'(a_m2s), W'(1));
        end
        if (sel_b && b_dm) begin
            n_mdone++; cap_m = b_rxm;
            rebuilt = wire_word(hist_b, PB);
            check(rebuilt == exp_b, "R4 R11 wire order and period", rebuilt, exp_b);
        end
        if ((!sel_b && a_ds) || (sel_b && b_ds)) begin
            n_sdone++; cap_s = sel_b ? b_rxs : a_rxs;
        end
        if (a_em || b_em) n_merr++;
        if (a_es || b_es) n_serr++;
    end

    task automatic summary();
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    task automatic pulse(input bit master);
        @(negedge clk);
        if (sel_b) begin if (master) b_sm = 1; else b_ss = 1; end
        else       begin if (master) a_sm = 1; else a_ss = 1; end
        @(negedge clk);
        a_sm = 0; a_ss = 0; b_sm = 0; b_ss = 0;
    endtask

    task automatic run_xfer(input bit pb, input logic [W-1:0] mtx, input logic [W-1:0] stx,
                            input int dm, input int ds, input bit poke);
        int n;
        sel_b = pb;
        n_mdone = 0; n_sdone = 0;
        if (pb) begin b_txm = mtx; b_txs = stx; exp_b = mtx; end
        else    begin a_txm = mtx; a_txs = stx; exp_a = mtx; end
        if (dm <= ds) begin
            repeat (dm) @(negedge clk); pulse(1);
            repeat (ds - dm) @(negedge clk); pulse(0);
        end else begin
            repeat (ds) @(negedge clk); pulse(0);
            repeat (dm - ds) @(negedge clk); pulse(1);
        end
        // R10: words changed after start must not reach the wire.
        a_txm = $urandom; a_txs = $urandom; b_txm = $urandom; b_txs = $urandom;
        if (poke) begin
            repeat (100) @(negedge clk);
            pulse(1); pulse(0);
        end
        n = 0;
        while (!(n_mdone > 0 && n_sdone > 0) && n < 3000) begin
            @(negedge clk); n++;
        end
        repeat (6) @(negedge clk);
        check(n_mdone == 1, "R7 master single done", W'(n_mdone), W'(1));
        check(n_sdone == 1, "R7 slave single done", W'(n_sdone), W'(1));
        check(cap_m == stx, pb ? "R11 R3/R5 master rx" : "R3/R5 master rx", cap_m, stx);
        check(cap_s == mtx, pb ? "R11 R3/R6 slave rx" : "R3/R6 slave rx", cap_s, mtx);
        check((pb ? b_rxm : a_rxm) == stx, "R7 rx held after done", pb ? b_rxm : a_rxm, stx);
        if (poke) check(cap_m == stx && cap_s == mtx, "R10 start while busy ignored", cap_m, stx);
    endtask

    initial begin
        int n;
        void'($urandom(32'd20110625));
        repeat (3) @(negedge clk);
        check(a_m2s == 1 && a_dm == 0 && a_em == 0, "R1 outputs in reset",
              {a_m2s, a_dm, a_em}, 3'b100);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(a_rxm == '0 && a_rxs == '0, "R1 rx after reset", a_rxm, '0);
        check(a_s2m == 1 && b_m2s == 1 && b_s2m == 1, "R1 lines idle high",
              {a_s2m, b_m2s, b_s2m}, 3'b111);

        // Directed corner words.
        run_xfer(0, 32'h8000_0001, 32'h0000_0000, 0, 0, 0);
        run_xfer(0, 32'hFFFF_FFFF, 32'h0000_0000, 0, 7, 0);
        run_xfer(0, 32'h0000_0000, 32'hFFFF_FFFF, 9, 0, 0);
        run_xfer(0, 32'hAAAA_5555, 32'h1234_5678, 3, 3, 1);

        // Constrained random: any words, start gap well below the timeout.
        for (int i = 0; i < 30; i++)
            run_xfer(0, $urandom, $urandom, int'($urandom_range(0, 40)),
                     int'($urandom_range(0, 40)), i % 7 == 3);

        // R11: slower bit period.
        run_xfer(1, 32'hF0F0_0F0F, 32'h0001_8000, 0, 5, 0);
        for (int i = 0; i < 8; i++)
            run_xfer(1, $urandom, $urandom, int'($urandom_range(0, 30)),
                     int'($urandom_range(0, 30)), 0);

        // R2 and R9: master alone, slave never answers.
        sel_b = 0; n_mdone = 0; n_merr = 0;
        pulse(1);
        check(a_m2s == 0, "R2 master drops line", W'(a_m2s), W'(0));
        n = 0;
        while (!a_em && n < TMO + 50) begin @(negedge clk); n++; end
        check(n >= TMO - 2 && n <= TMO, "R9 master timeout cycle", W'(n), W'(TMO - 1));
        check(a_m2s == 1 && n_mdone == 0, "R9 master line high, no done",
              {a_m2s, n_mdone[0]}, 2'b10);

        // R2 and R9: slave alone, master idle high.
        n_serr = 0; n_sdone = 0;
        pulse(0);
        repeat (20) @(negedge clk);
        check(a_s2m == 1, "R2 slave holds line high", W'(a_s2m), W'(1));
        n = 20;
        while (!a_es && n < TMO + 50) begin @(negedge clk); n++; end
        check(n >= TMO - 2 && n <= TMO, "R9 slave timeout cycle", W'(n), W'(TMO - 1));
        repeat (3) @(negedge clk);
        check(n_serr == 1 && n_sdone == 0, "R9 slave single error, no done",
              W'(n_serr), W'(1));

        // The link still works after the aborts.
        run_xfer(0, 32'hDEAD_BEEF, 32'hC0DE_F00D, 2, 0, 0);

        summary();
    end

endmodule